// File: doc/BRIEF.md
# Effective Address Generator for an 8-bit Processor Core

This block computes the effective address of an operand for each addressing mode of a classic 8-bit processor with a 16-bit address space. The instruction decoder pulses `start` and supplies several values in the same cycle: the mode code, the one or two operand bytes, the address of the operand byte itself, and the two index registers. Direct modes produce the address with no memory traffic. Indirect modes fetch a two-byte pointer through a byte-read port, low byte first. The port uses a request/valid handshake. The final address appears on `ea`, and `done` pulses for one cycle to mark it.

All arithmetic inside page zero wraps within page zero. This includes the location of a pointer's high byte. The high byte of an absolute pointer is fetched from the same page as its low byte, so the low-byte offset wraps instead of carrying into the next page. Absolute indexing and post-indexing carry across the full address width.

The controller is a four-state machine:
- **IDLE** waits for `start`. On `start` it goes to PTR_LO for an indirect mode and to DONE for a direct mode.
- **PTR_LO** requests the pointer low byte and moves to PTR_HI when `rd_valid` arrives.
- **PTR_HI** requests the high byte and moves to DONE when `rd_valid` arrives.
- **DONE** asserts `done` and returns to IDLE unconditionally.

Top module: `eagen_top`

## Requirements
- R1: Mode encoding on `mode` is:
  - 0: immediate, where `ea` = `op_loc`.
  - 1: page zero.
  - 2: page zero + X.
  - 3: page zero + Y.
  - 4: absolute.
  - 5: absolute + X.
  - 6: absolute + Y.
  - 7: page-zero indirect.
  - 8: page-zero pre-indexed (X) indirect.
  - 9: page-zero indirect post-indexed by Y.
  - 10: absolute indirect.
  - 11: absolute pre-indexed (X) indirect.
  - Codes 12 to 15 behave as immediate.
- R2: Modes 1 to 3 give `ea` = {0, (lo + index) mod 2^DW}. The result never leaves page zero.
- R3: Modes 4 to 6 give `ea` = ({hi,lo} + index) mod 2^AW, with full carry into the high byte.
- R4: Modes 7 to 9 read the pointer low byte at page-zero offset p and the high byte at page-zero offset (p+1) mod 2^DW. Here p = lo, or (lo + X) mod 2^DW for mode 8.
- R5: Mode 9 returns ({ptr_hi, ptr_lo} + Y) mod 2^AW, with carry into the high byte.
- R6: Mode 10 reads the pointer at q = {hi,lo}. Mode 11 reads it at q = ({hi,lo} + X) mod 2^AW. In both, the high byte is read at {q_high, (q_low + 1) mod 2^DW}, in the same page as the low byte.
- R7: Indirect modes issue exactly two reads, low byte first, one at a time. `rd_req` stays high with a stable `rd_addr` until `rd_valid`. `rd_req` is low in IDLE.
- R8: `done` is high for exactly one cycle per accepted request. `ea` holds its value until the next completion.
- R9: A `start` while a calculation is in progress is ignored. Input changes after acceptance do not alter the result.
- R10: During and after reset, `done` = 0, `rd_req` = 0 and `ea` = 0.
- R11: A direct mode accepted at a clock edge shows `done` in the following cycle and issues no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted in IDLE |
| mode | input | 4 | Addressing mode code (R1) |
| opnd_lo | input | DW | First operand byte |
| opnd_hi | input | DW | Second operand byte |
| op_loc | input | AW | Address of the operand byte (immediate result) |
| idx_x | input | DW | X index |
| idx_y | input | DW | Y index |
| rd_req | output | 1 | Pointer byte read request |
| rd_addr | output | AW | Pointer byte address |
| rd_data | input | DW | Returned byte |
| rd_valid | input | 1 | Read data valid; completes the request |
| ea | output | AW | Effective address |
| done | output | 1 | One-cycle completion strobe |

## Verification
The bench builds the block with DW = 4, which gives an 8-bit address space and 16-entry pages. At that size the operand low byte and the X index can be swept exhaustively for every mode code, including the reserved ones, across several high-byte values. The sweep therefore crosses every page-zero wrap, every pointer at the last offset of its page, and every carry from absolute indexing or post-indexing. The memory model answers each read one cycle late, so the hold-until-valid rule and the low-then-high read order are exercised on every indirect access.

// File: rtl/eagen_pkg.sv
package eagen_pkg;

    typedef enum logic [3:0] {
        AM_IMM     = 4'd0,
        AM_ZP      = 4'd1,
        AM_ZPX     = 4'd2,
        AM_ZPY     = 4'd3,
        AM_ABS     = 4'd4,
        AM_ABSX    = 4'd5,
        AM_ABSY    = 4'd6,
        AM_ZPIND   = 4'd7,
        AM_ZPXIND  = 4'd8,
        AM_ZPINDY  = 4'd9,
        AM_ABSIND  = 4'd10,
        AM_ABSXIND = 4'd11
    } am_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PTR_LO = 2'd1,
        ST_PTR_HI = 2'd2,
        ST_DONE   = 2'd3
    } st_e;

endpackage

// File: rtl/eagen_form.sv
// Decodes the mode and forms either the final address (direct modes)
// or the location of the pointer's low byte (indirect modes).
module eagen_form
    import eagen_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [3:0]      mode,
    input  logic [DW-1:0]   opnd_lo,
    input  logic [DW-1:0]   opnd_hi,
    input  logic [2*DW-1:0] op_loc,
    input  logic [DW-1:0]   idx_x,
    input  logic [DW-1:0]   idx_y,
    output logic [2*DW-1:0] direct_ea,
    output logic [2*DW-1:0] ptr_loc,
    output logic            is_ind,
    output logic            post_y
);
    localparam int AW = 2 * DW;

    logic [AW-1:0] base;
    logic [DW-1:0] zp_x;
    logic [DW-1:0] zp_y;
    logic [AW-1:0] abs_x;
    logic [AW-1:0] abs_y;

    // Page-zero sums are DW wide, so they wrap inside page zero.
    assign base  = {opnd_hi, opnd_lo};
    assign zp_x  = opnd_lo + idx_x;
    assign zp_y  = opnd_lo + idx_y;
    // Absolute sums carry across the whole address.
    assign abs_x = base + {{DW{1'b0}}, idx_x};
    assign abs_y = base + {{DW{1'b0}}, idx_y};

    always_comb begin
        direct_ea = op_loc;
        ptr_loc   = base;
        is_ind    = 1'b0;
        post_y    = 1'b0;
        case (am_e'(mode))
            AM_IMM:     direct_ea = op_loc;
            AM_ZP:      direct_ea = {{DW{1'b0}}, opnd_lo};
            AM_ZPX:     direct_ea = {{DW{1'b0}}, zp_x};
            AM_ZPY:     direct_ea = {{DW{1'b0}}, zp_y};
            AM_ABS:     direct_ea = base;
            AM_ABSX:    direct_ea = abs_x;
            AM_ABSY:    direct_ea = abs_y;
            AM_ZPIND: begin
                ptr_loc = {{DW{1'b0}}, opnd_lo};
                is_ind  = 1'b1;
            end
            AM_ZPXIND: begin
                ptr_loc = {{DW{1'b0}}, zp_x};
                is_ind  = 1'b1;
            end
            AM_ZPINDY: begin
                ptr_loc = {{DW{1'b0}}, opnd_lo};
                is_ind  = 1'b1;
                post_y  = 1'b1;
            end
            AM_ABSIND: begin
                ptr_loc = base;
                is_ind  = 1'b1;
            end
            AM_ABSXIND: begin
                ptr_loc = abs_x;
                is_ind  = 1'b1;
            end
            default:    direct_ea = op_loc;
        endcase
    end

endmodule

// File: rtl/eagen_wrapinc.sv
// Location of a pointer's high byte: next offset within the same page.
module eagen_wrapinc #(
    parameter int DW = 8
) (
    input  logic [2*DW-1:0] lo_loc,
    output logic [2*DW-1:0] hi_loc
);
    localparam int AW = 2 * DW;

    logic [DW-1:0] off_next;

    assign off_next = lo_loc[DW-1:0] + {{(DW-1){1'b0}}, 1'b1};
    assign hi_loc   = {lo_loc[AW-1:DW], off_next};

endmodule

// File: rtl/eagen_join.sv
// Joins fetched pointer bytes, optionally adding Y with full carry.
module eagen_join #(
    parameter int DW = 8
) (
    input  logic [DW-1:0]   ptr_hi,
    input  logic [DW-1:0]   ptr_lo,
    input  logic            add_y,
    input  logic [DW-1:0]   idx_y,
    output logic [2*DW-1:0] sum
);
    localparam int AW = 2 * DW;

    logic [AW-1:0] addend;

    assign addend = add_y ? {{DW{1'b0}}, idx_y} : {AW{1'b0}};
    assign sum    = {ptr_hi, ptr_lo} + addend;

endmodule

// File: rtl/eagen_fsm.sv
module eagen_fsm
    import eagen_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            is_ind,
    input  logic            post_y,
    input  logic [2*DW-1:0] ptr_loc,
    input  logic [2*DW-1:0] direct_ea,
    input  logic [DW-1:0]   idx_y,
    input  logic            rd_valid,
    input  logic [DW-1:0]   rd_data,
    output logic            rd_req,
    output logic [2*DW-1:0] rd_addr,
    output logic [2*DW-1:0] ea,
    output logic            done,
    output logic            busy,
    output logic            hi_phase
);
    localparam int AW = 2 * DW;

    st_e           state_q;
    st_e           state_d;
    logic [AW-1:0] ptr_q;
    logic          post_y_q;
    logic [DW-1:0] y_q;
    logic [DW-1:0] lo_q;
    logic [AW-1:0] ea_q;
    logic [AW-1:0] hi_loc;
    logic [AW-1:0] joined;

    eagen_wrapinc #(.DW(DW)) u_wrap (
        .lo_loc (ptr_q),
        .hi_loc (hi_loc)
    );

    eagen_join #(.DW(DW)) u_join (
        .ptr_hi (rd_data),
        .ptr_lo (lo_q),
        .add_y  (post_y_q),
        .idx_y  (y_q),
        .sum    (joined)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = is_ind ? ST_PTR_LO : ST_DONE;
            ST_PTR_LO: if (rd_valid) state_d = ST_PTR_HI;
            ST_PTR_HI: if (rd_valid) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            post_y_q <= 1'b0;
            y_q      <= '0;
            lo_q     <= '0;
            ea_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        ptr_q    <= ptr_loc;
                        post_y_q <= post_y;
                        y_q      <= idx_y;
                        if (!is_ind) ea_q <= direct_ea;
                    end
                end
                ST_PTR_LO: if (rd_valid) lo_q <= rd_data;
                ST_PTR_HI: if (rd_valid) ea_q <= joined;
                ST_DONE:   ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        rd_req   = 1'b0;
        rd_addr  = ptr_q;
        done     = 1'b0;
        hi_phase = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_PTR_LO: rd_req = 1'b1;
            ST_PTR_HI: begin
                rd_req   = 1'b1;
                rd_addr  = hi_loc;
                hi_phase = 1'b1;
            end
            ST_DONE:   done = 1'b1;
        endcase
    end

    assign busy = (state_q != ST_IDLE);
    assign ea   = ea_q;

endmodule

// File: rtl/eagen_top.sv
module eagen_top #(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        mode,
    input  logic [DW-1:0]     opnd_lo,
    input  logic [DW-1:0]     opnd_hi,
    input  logic [2*DW-1:0]   op_loc,
    input  logic [DW-1:0]     idx_x,
    input  logic [DW-1:0]     idx_y,
    output logic              rd_req,
    output logic [2*DW-1:0]   rd_addr,
    input  logic [DW-1:0]     rd_data,
    input  logic              rd_valid,
    output logic [2*DW-1:0]   ea,
    output logic              done
);
    localparam int AW = 2 * DW;

    logic [AW-1:0] direct_ea_w;
    logic [AW-1:0] ptr_loc_w;
    logic          is_ind_w;
    logic          post_y_w;
    logic          busy_w;
    logic          hi_phase_w;

    eagen_form #(.DW(DW)) u_form (
        .mode      (mode),
        .opnd_lo   (opnd_lo),
        .opnd_hi   (opnd_hi),
        .op_loc    (op_loc),
        .idx_x     (idx_x),
        .idx_y     (idx_y),
        .direct_ea (direct_ea_w),
        .ptr_loc   (ptr_loc_w),
        .is_ind    (is_ind_w),
        .post_y    (post_y_w)
    );

    eagen_fsm #(.DW(DW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .is_ind    (is_ind_w),
        .post_y    (post_y_w),
        .ptr_loc   (ptr_loc_w),
        .direct_ea (direct_ea_w),
        .idx_y     (idx_y),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .ea        (ea),
        .done      (done),
        .busy      (busy_w),
        .hi_phase  (hi_phase_w)
    );

endmodule

// File: rtl/eagen_chk.sv
module eagen_chk #(
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            rd_req,
    input logic [2*DW-1:0] rd_addr,
    input logic            rd_valid,
    input logic            done,
    input logic            busy,
    input logic            hi_phase
);
    localparam int AW = 2 * DW;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_req);

    // R6
    hi_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_valid && !hi_phase) |=>
        (rd_req && hi_phase &&
         rd_addr == {$past(rd_addr[AW-1:DW]),
                     $past(rd_addr[DW-1:0]) + {{(DW-1){1'b0}}, 1'b1}}));

    // R11
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (done != rd_req));

endmodule

bind eagen_top eagen_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .rd_valid (rd_valid),
    .done     (done),
    .busy     (busy_w),
    .hi_phase (hi_phase_w)
);

// File: tb/sim_eagen_top.sv
`timescale 1ns/1ps
module sim_eagen_top;
    localparam int DW = 4;
    localparam int AW = 2 * DW;
    localparam int M  = (1 << DW) - 1;
    localparam int P  = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [3:0]    mode = '0;
    logic [DW-1:0] opnd_lo = '0;
    logic [DW-1:0] opnd_hi = '0;
    logic [AW-1:0] op_loc = '0;
    logic [DW-1:0] idx_x = '0;
    logic [DW-1:0] idx_y = '0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data = '0;
    logic          rd_valid = 1'b0;
    logic [AW-1:0] ea;
    logic          done;

    int checks = 0;
    int fails  = 0;
    int nlog   = 0;
    logic [AW-1:0] rlog [4];

    always #5 clk = ~clk;

    eagen_top #(.DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .op_loc(op_loc),
        .idx_x(idx_x), .idx_y(idx_y), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid), .ea(ea), .done(done)
    );

    function automatic int mem(input int a);
        return ((a * 7) + (a >> 4) + 5) & M;
    endfunction

    // Memory model: answers one cycle after a request, logs accepted reads
    initial begin
        forever begin
            @(posedge clk);
            if (rd_req && rd_valid) begin
                if (nlog < 4) rlog[nlog] = rd_addr;
                nlog = nlog + 1;
            end
            rd_valid <= rst_n && rd_req && !rd_valid;
            rd_data  <= DW'(mem(int'(rd_addr)));
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void model(input int m, lo, hi, x, y,
                                  output int e, output int n, output int a0, output int a1);
        int base, oloc, p;
        base = (hi << DW) | lo;
        oloc = base ^ 'hA5;
        n = 0; a0 = 0; a1 = 0; e = oloc;
        case (m)
            1: e = lo;
            2: e = (lo + x) & M;
            3: e = (lo + y) & M;
            4: e = base;
            5: e = (base + x) & P;
            6: e = (base + y) & P;
            7, 9: begin a0 = lo; a1 = (lo + 1) & M; n = 2; end
            8: begin p = (lo + x) & M; a0 = p; a1 = (p + 1) & M; n = 2; end
            10: begin a0 = base; a1 = (base & ~M) | ((base + 1) & M); n = 2; end
            11: begin p = (base + x) & P; a0 = p; a1 = (p & ~M) | ((p + 1) & M); n = 2; end
            default: e = oloc;
        endcase
        if (n == 2) begin
            e = (mem(a1) << DW) | mem(a0);
            if (m == 9) e = (e + y) & P;
        end
    endfunction

    function automatic string tag(input int m);
        case (m)
            1, 2, 3: return "R2";
            4, 5, 6: return "R3";
            7, 8:    return "R4";
            9:       return "R5";
            10, 11:  return "R6";
            default: return "R1";
        endcase
    endfunction

    // Issue one request; returns cycles waited for done (-1 on timeout)
    task automatic issue(input int m, lo, hi, x, y, output int wait_cyc);
        int k;
        @(negedge clk);
        mode = 4'(m); opnd_lo = DW'(lo); opnd_hi = DW'(hi);
        idx_x = DW'(x); idx_y = DW'(y);
        op_loc = AW'(((hi << DW) | lo) ^ 'hA5);
        nlog = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // scramble inputs after acceptance (R9: must not matter)
        mode = ~mode; opnd_lo = ~opnd_lo; opnd_hi = ~opnd_hi;
        idx_x = ~idx_x; idx_y = ~idx_y; op_loc = ~op_loc;
        k = 0;
        while (!done && k < 40) begin
            @(negedge clk);
            k++;
        end
        wait_cyc = (k >= 40) ? -1 : k;
    endtask

    task automatic run_one(input int m, lo, hi, x, y);
        int e, n, a0, a1, w;
        logic [AW-1:0] held;
        model(m, lo, hi, x, y, e, n, a0, a1);
        issue(m, lo, hi, x, y, w);
        if (w < 0) begin
            check(1'b0, "R8 timeout", w, 0);
            return;
        end
        check(ea == AW'(e), tag(m), int'(ea), e);
        if (n == 2)
            check(nlog == 2 && rlog[0] == AW'(a0) && rlog[1] == AW'(a1), "R7 read order",
                  (int'(rlog[0]) << 8) | int'(rlog[1]), (a0 << 8) | a1);
        else
            check(w == 0 && nlog == 0, "R11 direct timing", (w << 8) | nlog, 0);
        held = ea;
        @(negedge clk);
        check(!done && ea == held, "R8 single pulse and hold", int'(done), 0);
    endtask

    initial begin
        int e, n, a0, a1, k, dones;
        #1;
        // R10: reset state
        check(!done && !rd_req && ea == '0, "R10 in reset", int'(ea), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !rd_req && ea == '0, "R10 after reset", int'(ea), 0);

        // Near-exhaustive sweep, reserved codes included (R1..R6)
        for (int m = 0; m < 16; m++)
            for (int hs = 0; hs < 3; hs++)
                for (int lo = 0; lo <= M; lo++)
                    for (int x = 0; x <= M; x++)
                        run_one(m, lo, (hs == 0) ? 0 : (hs == 1) ? 9 : M, x, (x * 5 + 3) & M);

        // R9: start while busy is ignored
        model(10, M, 6, 0, 0, e, n, a0, a1);
        @(negedge clk);
        mode = 4'd10; opnd_lo = DW'(M); opnd_hi = DW'(6);
        idx_x = '0; idx_y = '0; op_loc = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        mode = 4'd1; opnd_lo = DW'(3); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0; dones = 0;
        while (k < 20) begin
            if (done) begin
                dones++;
                check(ea == AW'(e), "R9 result unaffected", int'(ea), e);
            end
            @(negedge clk);
            k++;
        end
        check(dones == 1, "R9 one completion", dones, 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (180000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule